// File: doc/BRIEF.md
# Peripheral Stop Handshake Sequencer

This block runs the stop handshake that a group of peripherals must finish before the chip may drop into a low-power state. Each peripheral lane takes stop requests from two register sources: a domain source and a system source. A parameter marks each lane as owned by one CPU domain or as shared. An owned lane needs only its domain request. A shared lane needs both requests before it acts.

Once a lane's handshake is under way, the lane refuses new transfers. It then waits for its outstanding-transfer counter to drain to zero and raises its stop acknowledge. Lanes marked as bus masters go first. A bus-slave lane starts its handshake only after every master lane has acknowledged. This lets master traffic toward the slaves finish before the slaves close.

The block drives a single low-power-ready output. It is high only while every lane acknowledges and no interrupt is pending. Withdrawing a request reopens the lane to traffic at once and clears its acknowledge on the next clock edge.

Top module: `lp_stop_seq`

## Requirements
- R1: A shared lane (its DOM_ASSIGNED bit 0) never acknowledges unless both its domain and system stop requests are high.
- R2: An owned lane (its DOM_ASSIGNED bit 1) starts its handshake on the domain request alone, and its system request has no effect.
- R3: While a lane's handshake is active, xfer_rdy of that lane is low, and a transfer request in that state does not add to its outstanding count.
- R4: stop_ack of a lane rises on the clock edge at which the handshake is active and the outstanding count becomes zero, and never while transfers are outstanding.
- R5: A slave lane (its IS_MASTER bit 0) keeps accepting transfers and does not acknowledge until every master lane has acknowledged.
- R6: lp_ready is low whenever any lane's stop_ack is low.
- R7: lp_ready is low while irq_pend is high, even with every lane acknowledged.
- R8: When a lane's request condition is withdrawn, xfer_rdy returns high in the same cycle and stop_ack falls on the next clock edge.
- R9: A lane whose outstanding count has reached 2**CNT_W-1 shows xfer_rdy low and accepts nothing more.
- R10: After reset every stop_ack is low, lp_ready is low and, with no requests present, every xfer_rdy is high.
- R11: A completion pulse while a lane's outstanding count is zero is ignored, so the count does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req_dom | input | N | Stop request from the domain register source, one bit per lane |
| stop_req_sys | input | N | Stop request from the system register source, one bit per lane |
| xfer_req | input | N | New transfer offered to each lane |
| xfer_done | input | N | One in-flight transfer of the lane completed |
| irq_pend | input | 1 | An interrupt is pending |
| xfer_rdy | output | N | Lane accepts a new transfer this cycle |
| stop_ack | output | N | Lane has finished its stop handshake |
| lp_ready | output | 1 | Low-power entry permitted |

## Verification
The assertions take for granted that xfer_done is a plain per-cycle pulse. They allow it to arrive with nothing outstanding, because the design must ignore that case. They also assume requests may change in any cycle without a protocol. The stimulus keeps to this: it toggles each request bit at random and raises completions mostly when the bench's own count is nonzero, with occasional spurious ones. Directed phases fill a counter to its limit, hold slaves behind masters and pulse the interrupt line, so that each boundary case occurs at least once.

// File: rtl/lp_stop_seq.sv
module lp_stop_seq #(
  parameter int N = 4,
  parameter int CNT_W = 4,
  parameter logic [N-1:0] DOM_ASSIGNED = 4'b0101,
  parameter logic [N-1:0] IS_MASTER = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stop_req_dom,
  input  logic [N-1:0] stop_req_sys,
  input  logic [N-1:0] xfer_req,
  input  logic [N-1:0] xfer_done,
  input  logic         irq_pend,
  output logic [N-1:0] xfer_rdy,
  output logic [N-1:0] stop_ack,
  output logic         lp_ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [N-1:0] req_ok, go, accept, dec;
  logic [N-1:0][CNT_W-1:0] cnt, cnt_nxt;
  logic masters_done;

  assign masters_done = &(stop_ack | ~IS_MASTER);
  assign lp_ready = (&stop_ack) & ~irq_pend;

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (DOM_ASSIGNED[i]) begin : g_own
      assign req_ok[i] = stop_req_dom[i];
    end else begin : g_shared
      assign req_ok[i] = stop_req_dom[i] & stop_req_sys[i];
    end

    if (IS_MASTER[i]) begin : g_mst
      assign go[i] = req_ok[i];
    end else begin : g_slv
      assign go[i] = req_ok[i] & masters_done;
    end

    assign xfer_rdy[i] = ~go[i] & (cnt[i] != CNT_MAX);
    assign accept[i]   = xfer_req[i] & xfer_rdy[i];
    assign dec[i]      = xfer_done[i] & (cnt[i] != '0);
    assign cnt_nxt[i]  = cnt[i] - (dec[i] ? CNT_ONE : '0) + (accept[i] ? CNT_ONE : '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i]      <= '0;
        stop_ack[i] <= 1'b0;
      end else begin
        cnt[i]      <= cnt_nxt[i];
        stop_ack[i] <= go[i] & (cnt_nxt[i] == '0);
      end
    end
  end
endmodule

// File: rtl/lp_stop_seq_chk.sv
module lp_stop_seq_chk #(
  parameter int N = 4,
  parameter int CNT_W = 4,
  parameter logic [N-1:0] DOM_ASSIGNED = 4'b0101,
  parameter logic [N-1:0] IS_MASTER = 4'b0011
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N-1:0]            stop_req_dom,
  input logic [N-1:0]            stop_req_sys,
  input logic                    irq_pend,
  input logic [N-1:0]            xfer_rdy,
  input logic [N-1:0]            stop_ack,
  input logic                    lp_ready,
  input logic [N-1:0][CNT_W-1:0] cnt
);
  logic all_masters;
  assign all_masters = &(stop_ack | ~IS_MASTER);

  p_irq_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> !lp_ready);
  p_all_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ready |-> &stop_ack);

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack[i] |-> cnt[i] == '0);
    p_withdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_req_dom[i] |=> !stop_ack[i]);
    p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt[i]) |-> !xfer_rdy[i]);
    if (!DOM_ASSIGNED[i]) begin : g_shared
      p_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req_sys[i] |=> !stop_ack[i]);
    end
    if (!IS_MASTER[i]) begin : g_slave
      p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack[i] |-> $past(all_masters));
    end
  end
endmodule

bind lp_stop_seq lp_stop_seq_chk #(
  .N(N), .CNT_W(CNT_W), .DOM_ASSIGNED(DOM_ASSIGNED), .IS_MASTER(IS_MASTER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req_dom(stop_req_dom), .stop_req_sys(stop_req_sys),
  .irq_pend(irq_pend), .xfer_rdy(xfer_rdy), .stop_ack(stop_ack), .lp_ready(lp_ready),
  .cnt(cnt)
);

// File: tb/test_lp_stop_seq.sv
module test_lp_stop_seq;
  localparam int N = 4;
  localparam int CNT_W = 4;
  localparam logic [N-1:0] DOM = 4'b0101;
  localparam logic [N-1:0] MST = 4'b0011;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dom = '0, sys = '0, xreq = '0, xdone = '0;
  logic irq = 1'b0;
  logic [N-1:0] xfer_rdy, stop_ack;
  logic lp_ready;

  int checks = 0, errors = 0;
  int m_cnt [N];
  bit m_ack [N];
  string tag = "R10";
  int unsigned seed_dummy;

  always #4 clk = ~clk;

  lp_stop_seq #(.N(N), .CNT_W(CNT_W), .DOM_ASSIGNED(DOM), .IS_MASTER(MST)) i_lp_stop_seq (
    .clk(clk), .rst_n(rst_n), .stop_req_dom(dom), .stop_req_sys(sys),
    .xfer_req(xreq), .xfer_done(xdone), .irq_pend(irq),
    .xfer_rdy(xfer_rdy), .stop_ack(stop_ack), .lp_ready(lp_ready)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_go(int i);
    bit ok, mdone;
    ok = DOM[i] ? dom[i] : (dom[i] & sys[i]);
    mdone = 1'b1;
    for (int k = 0; k < N; k++) if (MST[k] && !m_ack[k]) mdone = 1'b0;
    return ok && (MST[i] || mdone);
  endfunction

  function automatic bit exp_lp();
    bit all = 1'b1;
    for (int k = 0; k < N; k++) all &= m_ack[k];
    return all && !irq;
  endfunction

  task automatic cycle(input int n = 1);
    for (int c = 0; c < n; c++) begin
      int nc [N];
      bit na [N];
      #1;
      for (int i = 0; i < N; i++) begin
        bit g, rdy, acc, dc;
        g = exp_go(i);
        rdy = !g && (m_cnt[i] != MAXC);
        acc = xreq[i] && rdy;
        dc = xdone[i] && (m_cnt[i] > 0);
        nc[i] = m_cnt[i] - int'(dc) + int'(acc);
        na[i] = g && (nc[i] == 0);
        check(xfer_rdy[i] == rdy, $sformatf("xfer_rdy[%0d]", i), xfer_rdy[i], rdy);
        check(stop_ack[i] == m_ack[i], $sformatf("stop_ack[%0d]", i), stop_ack[i], m_ack[i]);
      end
      check(lp_ready == exp_lp(), "lp_ready", lp_ready, exp_lp());
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = nc[i];
        m_ack[i] = na[i];
      end
      #1;
    end
  endtask

  task automatic clear_inputs();
    dom = '0; sys = '0; xreq = '0; xdone = '0; irq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_ack[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    tag = "R10";
    check(stop_ack == '0, "reset stop_ack", stop_ack, 0);
    check(xfer_rdy == '1, "reset xfer_rdy", xfer_rdy, 15);
    check(lp_ready == 1'b0, "reset lp_ready", lp_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cycle(2);

    tag = "R1";
    dom[1] = 1'b1; cycle(4);
    check(stop_ack[1] == 1'b0, "shared lane one request", stop_ack[1], 0);
    sys[1] = 1'b1; cycle(2);
    check(stop_ack[1] == 1'b1, "shared lane both requests", stop_ack[1], 1);
    clear_inputs(); cycle(2);

    tag = "R2";
    sys[0] = 1'b1; cycle(3);
    check(stop_ack[0] == 1'b0, "owned lane system request only", stop_ack[0], 0);
    sys[0] = 1'b0; dom[0] = 1'b1; cycle(2);
    check(stop_ack[0] == 1'b1, "owned lane domain request", stop_ack[0], 1);
    clear_inputs(); cycle(2);

    tag = "R4";
    xreq[1] = 1'b1; cycle(3); xreq[1] = 1'b0;
    dom[1] = 1'b1; sys[1] = 1'b1;
    tag = "R3";
    xreq[1] = 1'b1; cycle(3);
    tag = "R4";
    xreq[1] = 1'b0;
    check(stop_ack[1] == 1'b0, "ack with transfers outstanding", stop_ack[1], 0);
    xdone[1] = 1'b1; cycle(3); xdone[1] = 1'b0; cycle(1);
    check(stop_ack[1] == 1'b1, "ack after drain", stop_ack[1], 1);
    clear_inputs(); cycle(2);

    tag = "R5";
    dom[2] = 1'b1; xreq[2] = 1'b1; cycle(3);
    check(stop_ack[2] == 1'b0 && xfer_rdy[2] == 1'b1, "slave before masters", stop_ack[2], 0);
    xreq[2] = 1'b0; dom[0] = 1'b1; dom[1] = 1'b1; sys[1] = 1'b1; cycle(2);
    xdone[2] = 1'b1; cycle(4); xdone[2] = 1'b0; cycle(2);
    check(stop_ack[2] == 1'b1, "slave after masters", stop_ack[2], 1);

    tag = "R6";
    check(lp_ready == 1'b0, "one lane unacked", lp_ready, 0);
    dom[3] = 1'b1; sys[3] = 1'b1; cycle(2);
    check(lp_ready == 1'b1, "all lanes acked", lp_ready, 1);
    tag = "R7";
    irq = 1'b1; cycle(1);
    check(lp_ready == 1'b0, "pending interrupt", lp_ready, 0);
    irq = 1'b0; cycle(1);

    tag = "R8";
    sys[3] = 1'b0; #1;
    check(xfer_rdy[3] == 1'b1, "rdy same cycle", xfer_rdy[3], 1);
    check(stop_ack[3] == 1'b1, "ack still high before edge", stop_ack[3], 1);
    cycle(1);
    check(stop_ack[3] == 1'b0, "ack low after edge", stop_ack[3], 0);
    clear_inputs(); cycle(2);

    tag = "R9";
    xreq[3] = 1'b1; cycle(MAXC + 3);
    check(xfer_rdy[3] == 1'b0, "counter full", xfer_rdy[3], 0);
    xreq[3] = 1'b0; xdone[3] = 1'b1; cycle(MAXC + 2); xdone[3] = 1'b0; cycle(1);

    tag = "R11";
    xdone[2] = 1'b1; cycle(3); xdone[2] = 1'b0;
    xreq[2] = 1'b1; cycle(1); xreq[2] = 1'b0;
    xdone[2] = 1'b1; cycle(1); xdone[2] = 1'b0;
    dom[0] = 1'b1; dom[1] = 1'b1; sys[1] = 1'b1; dom[2] = 1'b1; cycle(4);
    check(stop_ack[2] == 1'b1, "no wrap after spurious done", stop_ack[2], 1);
    clear_inputs(); cycle(2);

    tag = "R3 R4 R6 random";
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom % 8 == 0) dom[i] = ~dom[i];
        if ($urandom % 8 == 0) sys[i] = ~sys[i];
        xreq[i] = ($urandom % 2) == 0;
        xdone[i] = (m_cnt[i] > 0) ? (($urandom % 2) == 0) : (($urandom % 16) == 0);
      end
      if ($urandom % 8 == 0) irq = ~irq;
      cycle(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule